// File: doc/BRIEF.md
# Chip-Select Output Unit

This unit drives a bank of chip-select lines for an SPI master. Every line keeps a one-bit internal level. Software changes that level through a write-only port, where each line has its own "raise" bit and its own "lower" bit. A single write can therefore move any subset of lines without a read-modify-write, and lines whose bits are both zero keep their level.

A separate configuration register holds two masks. The first decides, line by line, whether the SPI controller owns the line as a chip-select. The second gives each owned line an output inversion, so that a device whose select is active-high sees the correct polarity while software keeps working in the usual "low means selected" sense. A line that is not owned behaves as a plain general-purpose output and shows its internal level unchanged. A status port returns the internal levels so that software can read them back.

Top module: `cs_out_unit`

## Requirements
- R1: While `rst_n` is low, the configuration register is zero and every internal level is 1, so both `cs_state` and `cs_n` read all ones.
- R2: A cycle with `cfg_we` high loads `cfg_wdata`. Bit NUM_CS+n is the ownership bit of line n and bit n is its inversion bit. The new values take effect on `cs_n` in the cycle after the write.
- R3: A cycle with `force_we` high and `force_wdata[NUM_CS+n]` set makes the internal level of line n equal to 1 (deselected) from the next cycle.
- R4: A cycle with `force_we` high, `force_wdata[n]` set and `force_wdata[NUM_CS+n]` clear makes the internal level of line n equal to 0 (selected) from the next cycle.
- R5: When the raise bit and the lower bit of the same line are both set in one write, the line's level becomes 1.
- R6: In a forced-output write, a line whose raise bit and lower bit are both zero keeps its internal level.
- R7: For a line whose ownership bit is 1, `cs_n[n]` equals the internal level XOR the inversion bit.
- R8: For a line whose ownership bit is 0, `cs_n[n]` equals the internal level and the inversion bit has no effect.
- R9: `cs_state` always returns the current internal levels of all lines.
- R10: In a cycle without `force_we`, no internal level changes. A configuration write alone leaves every level as it was.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| cfg_we | input | 1 | Configuration write strobe |
| cfg_wdata | input | 2*NUM_CS | Ownership mask in the upper half, inversion mask in the lower half |
| force_we | input | 1 | Forced-output write strobe |
| force_wdata | input | 2*NUM_CS | Raise bits in the upper half, lower bits in the lower half |
| cs_state | output | NUM_CS | Internal level of every line |
| cs_n | output | NUM_CS | Chip-select pin levels |

## Verification
The assertions expect `rst_n` to be low at the first clock edge. They also expect both write strobes to be known in every cycle after reset, because the hold and update properties compare each level with its value one cycle earlier. The bench starts in reset and drives every input to a defined value at each falling edge. Its random phase draws both strobes and both data words with `$urandom`, so same-line raise/lower collisions, all-zero writes and writes to both ports in one cycle all occur inside that envelope.

// File: rtl/cs_out_pkg.sv
package cs_out_pkg;

    // Default number of chip-select lines in the bank.
    localparam int unsigned CS_DEFAULT_LINES = 8;

    // Level driven onto one pin, from its line level and configuration.
    function automatic logic cs_pin_level(input logic level,
                                          input logic owned,
                                          input logic invert);
        return owned ? (level ^ invert) : level;
    endfunction

endpackage

// File: rtl/cs_cfg_reg.sv
module cs_cfg_reg #(
    parameter int unsigned N = cs_out_pkg::CS_DEFAULT_LINES
) (
    input  logic           clk,
    input  logic           rst_n,
    input  logic           we,
    input  logic [2*N-1:0] wdata,
    output logic [N-1:0]   own_o,
    output logic [N-1:0]   inv_o
);
    localparam int unsigned OWN_LSB = N;

    typedef struct packed {
        logic [N-1:0] own;
        logic [N-1:0] inv;
    } cfg_t;

    cfg_t cfg_d, cfg_q;

    always_comb begin
        cfg_d = cfg_q;
        if (we) begin
            cfg_d.own = wdata[OWN_LSB +: N];
            cfg_d.inv = wdata[0 +: N];
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) cfg_q <= '0;
        else        cfg_q <= cfg_d;
    end

    assign own_o = cfg_q.own;
    assign inv_o = cfg_q.inv;
endmodule

// File: rtl/cs_force_state.sv
module cs_force_state #(
    parameter int unsigned N = cs_out_pkg::CS_DEFAULT_LINES
) (
    input  logic           clk,
    input  logic           rst_n,
    input  logic           we,
    input  logic [2*N-1:0] wdata,
    output logic [N-1:0]   level_o
);
    localparam int unsigned RAISE_LSB = N;

    typedef struct packed {
        logic [N-1:0] level;
    } st_t;

    st_t st_d, st_q;

    always_comb begin
        st_d = st_q;
        if (we) begin
            for (int i = 0; i < int'(N); i++) begin
                // raise has priority over lower on the same line
                if (wdata[RAISE_LSB + i])  st_d.level[i] = 1'b1;
                else if (wdata[i])         st_d.level[i] = 1'b0;
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '{level: '1};
        else        st_q <= st_d;
    end

    assign level_o = st_q.level;
endmodule

// File: rtl/cs_pin_drive.sv
module cs_pin_drive #(
    parameter int unsigned N = cs_out_pkg::CS_DEFAULT_LINES
) (
    input  logic [N-1:0] level_i,
    input  logic [N-1:0] own_i,
    input  logic [N-1:0] inv_i,
    output logic [N-1:0] pin_o
);
    for (genvar g = 0; g < int'(N); g++) begin : g_line
        assign pin_o[g] = cs_out_pkg::cs_pin_level(level_i[g], own_i[g], inv_i[g]);
    end
endmodule

// File: rtl/cs_out_unit.sv
module cs_out_unit #(
    parameter int unsigned NUM_CS = cs_out_pkg::CS_DEFAULT_LINES
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              cfg_we,
    input  logic [2*NUM_CS-1:0] cfg_wdata,
    input  logic              force_we,
    input  logic [2*NUM_CS-1:0] force_wdata,
    output logic [NUM_CS-1:0] cs_state,
    output logic [NUM_CS-1:0] cs_n
);
    logic [NUM_CS-1:0] cfg_own;
    logic [NUM_CS-1:0] cfg_inv;
    logic [NUM_CS-1:0] line_level;

    cs_cfg_reg #(.N(NUM_CS)) u_cfg (
        .clk   (clk),
        .rst_n (rst_n),
        .we    (cfg_we),
        .wdata (cfg_wdata),
        .own_o (cfg_own),
        .inv_o (cfg_inv)
    );

    cs_force_state #(.N(NUM_CS)) u_state (
        .clk     (clk),
        .rst_n   (rst_n),
        .we      (force_we),
        .wdata   (force_wdata),
        .level_o (line_level)
    );

    cs_pin_drive #(.N(NUM_CS)) u_pins (
        .level_i (line_level),
        .own_i   (cfg_own),
        .inv_i   (cfg_inv),
        .pin_o   (cs_n)
    );

    assign cs_state = line_level;
endmodule

// File: rtl/cs_out_unit_chk.sv
module cs_out_unit_chk #(
    parameter int unsigned N = cs_out_pkg::CS_DEFAULT_LINES
) (
    input logic           clk,
    input logic           rst_n,
    input logic           cfg_we,
    input logic [2*N-1:0] cfg_wdata,
    input logic           force_we,
    input logic [2*N-1:0] force_wdata,
    input logic [N-1:0]   cs_state,
    input logic [N-1:0]   cfg_own,
    input logic [N-1:0]   cfg_inv
);
    assert_reset_state_R1: assert property (@(posedge clk)
        !rst_n |=> (cs_state == '1));

    assert_cfg_load_R2: assert property (@(posedge clk) disable iff (!rst_n)
        cfg_we |=> ({cfg_own, cfg_inv} == $past(cfg_wdata)));

    assert_state_hold_R10: assert property (@(posedge clk) disable iff (!rst_n)
        !force_we |=> $stable(cs_state));

    for (genvar g = 0; g < int'(N); g++) begin : g_chk
        assert_raise_R3: assert property (@(posedge clk) disable iff (!rst_n)
            (force_we && force_wdata[N+g]) |=> cs_state[g]);

        assert_lower_R4: assert property (@(posedge clk) disable iff (!rst_n)
            (force_we && force_wdata[g] && !force_wdata[N+g]) |=> !cs_state[g]);

        assert_both_R5: assert property (@(posedge clk) disable iff (!rst_n)
            (force_we && force_wdata[g] && force_wdata[N+g]) |=> cs_state[g]);

        assert_untouched_R6: assert property (@(posedge clk) disable iff (!rst_n)
            (force_we && !force_wdata[g] && !force_wdata[N+g]) |=> $stable(cs_state[g]));
    end
endmodule

bind cs_out_unit cs_out_unit_chk #(.N(NUM_CS)) u_chk (
    .clk         (clk),
    .rst_n       (rst_n),
    .cfg_we      (cfg_we),
    .cfg_wdata   (cfg_wdata),
    .force_we    (force_we),
    .force_wdata (force_wdata),
    .cs_state    (cs_state),
    .cfg_own     (cfg_own),
    .cfg_inv     (cfg_inv)
);

// File: tb/tb_cs_out_unit.sv
module tb_cs_out_unit;
    localparam int N = 8;

    logic           clk = 1'b0;
    logic           rst_n = 1'b0;
    logic           cfg_we = 1'b0;
    logic [2*N-1:0] cfg_wdata = '0;
    logic           force_we = 1'b0;
    logic [2*N-1:0] force_wdata = '0;
    logic [N-1:0]   cs_state;
    logic [N-1:0]   cs_n;

    int n_tests = 0;
    int n_fail  = 0;
    bit finished = 1'b0;

    logic [N-1:0] m_own = '0, m_inv = '0, m_lvl = '1;

    always #2.5 clk = ~clk;

    cs_out_unit #(.NUM_CS(N)) dut (
        .clk(clk), .rst_n(rst_n), .cfg_we(cfg_we), .cfg_wdata(cfg_wdata),
        .force_we(force_we), .force_wdata(force_wdata),
        .cs_state(cs_state), .cs_n(cs_n)
    );

    function automatic logic [N-1:0] exp_pins(input logic [N-1:0] lvl,
                                              input logic [N-1:0] own,
                                              input logic [N-1:0] inv);
        logic [N-1:0] r;
        for (int i = 0; i < N; i++) r[i] = own[i] ? (lvl[i] ^ inv[i]) : lvl[i];
        return r;
    endfunction

    function automatic logic [N-1:0] exp_level(input logic [N-1:0] lvl,
                                               input logic we,
                                               input logic [2*N-1:0] d);
        logic [N-1:0] r = lvl;
        if (we)
            for (int i = 0; i < N; i++)
                if (d[N+i]) r[i] = 1'b1;
                else if (d[i]) r[i] = 1'b0;
        return r;
    endfunction

    task automatic check(input string req, input logic [N-1:0] act, input logic [N-1:0] exp);
        n_tests++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s: actual %b expected %b", req, act, exp);
        end
    endtask

    // drive at falling edge, update model, sample 1 ns after the rising edge
    task automatic step(input logic cw, input logic [2*N-1:0] cd,
                        input logic fw, input logic [2*N-1:0] fd);
        @(negedge clk);
        cfg_we = cw; cfg_wdata = cd; force_we = fw; force_wdata = fd;
        m_lvl = exp_level(m_lvl, fw, fd);
        if (cw) begin m_own = cd[2*N-1:N]; m_inv = cd[N-1:0]; end
        @(posedge clk);
        #1;
        cfg_we = 1'b0; force_we = 1'b0;
    endtask

    initial begin
        #(200000 * 5);
        if (!finished) begin
            n_tests++; n_fail++;
            $display("FAIL watchdog: actual running expected done");
            $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
            $finish;
        end
    end

    initial begin
        int unsigned seed_val;
        seed_val = $urandom(32'h00c5_5eed);
        repeat (3) @(posedge clk);
        #1;
        check("R1 state", cs_state, '1);
        check("R1 pins", cs_n, '1);
        @(negedge clk); rst_n = 1'b1;

        // R3: deselect all (already high) then lower lines 0 and 2 via R4
        step(0, '0, 1, 16'hFF00);
        check("R3 all raised", cs_state, 8'hFF);
        step(0, '0, 1, 16'h0005);
        check("R4 lower 0,2", cs_state, 8'hFA);
        check("R8 unowned pins follow level", cs_n, 8'hFA);
        // R2 + R7: own lines 0..5, invert line 2
        step(1, 16'h3F04, 0, '0);
        check("R10 cfg write keeps level", cs_state, 8'hFA);
        check("R2/R7 owned pins", cs_n, exp_pins(m_lvl, m_own, m_inv));
        check("R7 line2 inverted", cs_n, 8'hFE);
        // R5: both bits on line 0 and 7
        step(0, '0, 1, 16'h8181);
        check("R5 both set gives high", cs_state, 8'hFB);
        // R6: only line 3 lowered, others untouched
        step(0, '0, 1, 16'h0008);
        check("R6 untouched lines hold", cs_state, 8'hF3);
        // R8: invert bits on unowned lines 6,7 have no effect
        step(1, 16'h00C0, 0, '0);
        check("R8 invert ignored when unowned", cs_n, 8'hF3);
        // R10: idle cycles
        step(0, '0, 0, 16'hFFFF);
        check("R10 idle hold", cs_state, 8'hF3);
        check("R9 status readback", cs_state, m_lvl);
        // cfg and force in the same cycle
        step(1, 16'hFFFF, 1, 16'h00FF);
        check("R2 joint write pins", cs_n, 8'hFF);
        check("R4 joint write level", cs_state, 8'h00);

        for (int k = 0; k < 400; k++) begin
            logic cw, fw;
            logic [2*N-1:0] cd, fd;
            cw = ($urandom % 4) == 0;
            fw = ($urandom % 3) != 0;
            cd = 16'($urandom);
            fd = 16'($urandom);
            step(cw, cd, fw, fd);
            check("R9 random status", cs_state, m_lvl);
            check("R7 random pins", cs_n, exp_pins(m_lvl, m_own, m_inv));
        end

        finished = 1'b1;
        $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    end
endmodule